// File: doc/BRIEF.md
# Load Queue Read-After-Write Violation Detector

This block keeps a circular queue of in-flight loads in program order. For each load it records the word address and whether the load has already read memory. Loads may execute before older stores have produced their addresses. When a store later broadcasts its address, the block looks for loads that come after that store in program order, have already executed and read the same word. Any such load read a stale value. The block then reports the oldest of them as the point from which the pipeline has to restart.

Each load gets a tag when it is allocated. A tag is the slot index with one extra wrap bit on top, and it advances modulo twice the depth. The tag is used to mark the load as executed, to give a store its position in program order, to squash the queue back to a load, and to name the restart point. Retirement frees loads at the head. A squash drops every load younger than a given tag in a single cycle. `DEPTH` must be a power of two.

Top module: `lq_raw_detector`

## Requirements
- R1: After reset the queue is empty, `lqFull` is 0, `allocTag` is 0 and `violValid` is 0.
- R2: `allocTag` shows the tag that the next allocation will receive. Each accepted allocation advances it by one, modulo 2*DEPTH. `lqFull` is 1 while DEPTH loads are live. An allocation requested while the queue is full is ignored and changes neither `allocTag` nor `lqFull`.
- R3: The cycle after a store broadcast whose word address equals that of a live, executed load at or after position `stAge`, `violValid` is 1 and `violTag` carries that load's tag.
- R4: A load that has not executed since it was allocated never matches. This includes a reused slot that still holds the address of an earlier load.
- R5: Loads before position `stAge` (older than the store) never match.
- R6: When several loads match, `violTag` names the oldest of them in program order, and this holds across tag wrap-around.
- R7: Addresses are compared as words. Bits [1:0] are ignored and every bit from 2 upward must be equal.
- R8: Retirement removes the head load. A retired load no longer counts toward `lqFull`, and `allocTag` is unchanged by retirement.
- R9: A squash with tag T removes every load younger than T. The next `allocTag` is T+1, and the removed loads can no longer match a store.
- R10: In any cycle that does not follow a store broadcast with a match, `violValid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| allocValid | input | 1 | Allocate one load at the tail |
| allocTag | output | TAGW | Tag that the next allocated load receives |
| lqFull | output | 1 | All DEPTH entries are live |
| execValid | input | 1 | A load has executed |
| execTag | input | TAGW | Tag of the executing load |
| execAddr | input | ADDR_W | Byte address the load read |
| stValid | input | 1 | A store broadcasts its address |
| stAge | input | TAGW | Tag of the first load after the store in program order |
| stAddr | input | ADDR_W | Store byte address |
| retireValid | input | 1 | Free the head load |
| squashValid | input | 1 | Drop the loads younger than squashTag |
| squashTag | input | TAGW | Youngest load that survives the squash |
| violValid | output | 1 | A violation was found by the previous store |
| violTag | output | TAGW | Tag of the oldest offending load (restart point) |

## Verification
The violation result is registered and is due exactly one cycle after the store broadcast. The driver therefore queues each expected result, stamped with the cycle count one past the store cycle. A monitor compares it at the falling edge of that cycle and flags any `violValid` that has no expectation due. `allocTag` and `lqFull` follow directly from the pointers, so they are valid in the cycle after an allocation, retirement or squash, and they are read at the next falling edge before the next stimulus is applied. The stimulus fills the queue, wraps tags into reused slots that hold stale addresses, and squashes over executed entries.

// File: rtl/lq_pkg.sv
package lq_pkg;

  // Strobes the control issues to the datapath in one cycle.
  typedef struct packed {
    logic allocFire;
    logic execFire;
    logic storeFire;
    logic retireFire;
    logic squashFire;
  } lqStrobes_t;

endpackage

// File: rtl/lq_ctrl.sv
module lq_ctrl
  import lq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int TAGW  = $clog2(DEPTH) + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            allocValid,
  input  logic            execValid,
  input  logic [TAGW-1:0] execTag,
  input  logic            stValid,
  input  logic [TAGW-1:0] stAge,
  input  logic            retireValid,
  input  logic            squashValid,
  input  logic [TAGW-1:0] squashTag,
  output lqStrobes_t      strobes,
  output logic [TAGW-1:0] headPtr,
  output logic [TAGW-1:0] tailPtr,
  output logic [TAGW-1:0] count,
  output logic [TAGW-1:0] stOff,
  output logic            full
);

  localparam logic [TAGW-1:0] DEPTH_T = TAGW'(DEPTH);

  logic [TAGW-1:0] execOff;
  logic [TAGW-1:0] squashOff;
  logic            isEmpty;

  assign count     = tailPtr - headPtr;
  assign full      = (count == DEPTH_T);
  assign isEmpty   = (count == '0);
  assign execOff   = execTag - headPtr;
  assign squashOff = squashTag - headPtr;
  assign stOff     = stAge - headPtr;

  always_comb begin
    strobes            = '0;
    strobes.squashFire = squashValid && (squashOff < count);
    strobes.allocFire  = allocValid && !full && !squashValid;
    strobes.retireFire = retireValid && !isEmpty;
    strobes.execFire   = execValid && (execOff < count);
    strobes.storeFire  = stValid;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      headPtr <= '0;
      tailPtr <= '0;
    end else begin
      if (strobes.retireFire) headPtr <= headPtr + 1'b1;
      if (strobes.squashFire) tailPtr <= squashTag + 1'b1;
      else if (strobes.allocFire) tailPtr <= tailPtr + 1'b1;
    end
  end

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= DEPTH_T);

  p_full_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    full && allocValid && !squashValid |=> tailPtr == $past(tailPtr));

  p_retire_head_r8: assert property (@(posedge clk) disable iff (!rst_n)
    retireValid && !isEmpty |=> headPtr == $past(headPtr) + 1'b1);

  p_squash_tail_r9: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.squashFire |=> tailPtr == $past(squashTag) + 1'b1);

endmodule

// File: rtl/lq_data.sv
module lq_data
  import lq_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int ADDR_W   = 32,
  parameter int WORD_LSB = 2,
  parameter int IDXW     = $clog2(DEPTH),
  parameter int TAGW     = IDXW + 1,
  parameter int WORD_W   = ADDR_W - WORD_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  lqStrobes_t        strobes,
  input  logic [TAGW-1:0]   headPtr,
  input  logic [TAGW-1:0]   tailPtr,
  input  logic [TAGW-1:0]   count,
  input  logic [TAGW-1:0]   stOff,
  input  logic [TAGW-1:0]   execTag,
  input  logic [WORD_W-1:0] execWord,
  input  logic [WORD_W-1:0] stWord,
  output logic              violValid,
  output logic [TAGW-1:0]   violTag
);

  logic [WORD_W-1:0] wordQ [DEPTH];
  logic [DEPTH-1:0]  execQ;
  logic [DEPTH-1:0]  hitVec;
  logic [DEPTH-1:0]  firstHit;
  logic [TAGW-1:0]   winOff;
  logic              found;

  // Executed flag: cleared on allocation, set on execution.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      execQ <= '0;
    end else begin
      if (strobes.allocFire) execQ[tailPtr[IDXW-1:0]] <= 1'b0;
      if (strobes.execFire)  execQ[execTag[IDXW-1:0]] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.execFire) wordQ[execTag[IDXW-1:0]] <= execWord;
  end

  // Search in program order: position k counts from the head.
  for (genvar k = 0; k < DEPTH; k++) begin : g_search
    logic [IDXW-1:0] slot;
    assign slot = headPtr[IDXW-1:0] + IDXW'(k);
    assign hitVec[k] = (TAGW'(k) < count) && (TAGW'(k) >= stOff) &&
                       execQ[slot] && (wordQ[slot] == stWord);
  end

  always_comb begin
    firstHit = '0;
    winOff   = '0;
    found    = 1'b0;
    for (int k = 0; k < DEPTH; k++) begin
      if (!found && hitVec[k]) begin
        found       = 1'b1;
        firstHit[k] = 1'b1;
        winOff      = TAGW'(k);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      violValid <= 1'b0;
      violTag   <= '0;
    end else begin
      violValid <= strobes.storeFire && found;
      if (strobes.storeFire && found) violTag <= headPtr + winOff;
    end
  end

  p_one_winner_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(firstHit));

  p_viol_needs_store_r10: assert property (@(posedge clk) disable iff (!rst_n)
    violValid |-> $past(strobes.storeFire));

  p_viol_executed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.storeFire && found |=> execQ[violTag[IDXW-1:0]]);

  p_viol_young_r5: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.storeFire && found |=> (violTag - $past(headPtr)) >= $past(stOff));

endmodule

// File: rtl/lq_raw_detector.sv
module lq_raw_detector
  import lq_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int ADDR_W   = 32,
  parameter int WORD_LSB = 2,
  parameter int TAGW     = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              allocValid,
  output logic [TAGW-1:0]   allocTag,
  output logic              lqFull,
  input  logic              execValid,
  input  logic [TAGW-1:0]   execTag,
  input  logic [ADDR_W-1:0] execAddr,
  input  logic              stValid,
  input  logic [TAGW-1:0]   stAge,
  input  logic [ADDR_W-1:0] stAddr,
  input  logic              retireValid,
  input  logic              squashValid,
  input  logic [TAGW-1:0]   squashTag,
  output logic              violValid,
  output logic [TAGW-1:0]   violTag
);

  localparam int WORD_W = ADDR_W - WORD_LSB;

  lqStrobes_t      strobes;
  logic [TAGW-1:0] headPtr;
  logic [TAGW-1:0] tailPtr;
  logic [TAGW-1:0] count;
  logic [TAGW-1:0] stOff;
  logic            unusedLowBits;

  assign unusedLowBits = ^{execAddr[WORD_LSB-1:0], stAddr[WORD_LSB-1:0]};
  assign allocTag      = tailPtr;

  lq_ctrl #(.DEPTH(DEPTH), .TAGW(TAGW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .allocValid (allocValid),
    .execValid  (execValid),
    .execTag    (execTag),
    .stValid    (stValid),
    .stAge      (stAge),
    .retireValid(retireValid),
    .squashValid(squashValid),
    .squashTag  (squashTag),
    .strobes    (strobes),
    .headPtr    (headPtr),
    .tailPtr    (tailPtr),
    .count      (count),
    .stOff      (stOff),
    .full       (lqFull)
  );

  lq_data #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W), .WORD_LSB(WORD_LSB),
    .IDXW($clog2(DEPTH)), .TAGW(TAGW), .WORD_W(WORD_W)
  ) u_data (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobes  (strobes),
    .headPtr  (headPtr),
    .tailPtr  (tailPtr),
    .count    (count),
    .stOff    (stOff),
    .execTag  (execTag),
    .execWord (execAddr[ADDR_W-1:WORD_LSB]),
    .stWord   (stAddr[ADDR_W-1:WORD_LSB]),
    .violValid(violValid),
    .violTag  (violTag)
  );

endmodule

// File: tb/tb_lq_raw_detector.sv
`timescale 1ns/1ps
module tb_lq_raw_detector;

  localparam int DEPTH = 8;
  localparam int TAGW  = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            allocValid = 1'b0;
  logic [TAGW-1:0] allocTag;
  logic            lqFull;
  logic            execValid = 1'b0;
  logic [TAGW-1:0] execTag = '0;
  logic [31:0]     execAddr = '0;
  logic            stValid = 1'b0;
  logic [TAGW-1:0] stAge = '0;
  logic [31:0]     stAddr = '0;
  logic            retireValid = 1'b0;
  logic            squashValid = 1'b0;
  logic [TAGW-1:0] squashTag = '0;
  logic            violValid;
  logic [TAGW-1:0] violTag;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 0;

  typedef struct {
    int    due;
    bit    v;
    int    tag;
    string req;
  } expItem_t;
  expItem_t expQ[$];

  always #2 clk = ~clk;

  lq_raw_detector #(.DEPTH(DEPTH), .TAGW(TAGW)) dut (
    .clk(clk), .rst_n(rst_n),
    .allocValid(allocValid), .allocTag(allocTag), .lqFull(lqFull),
    .execValid(execValid), .execTag(execTag), .execAddr(execAddr),
    .stValid(stValid), .stAge(stAge), .stAddr(stAddr),
    .retireValid(retireValid), .squashValid(squashValid), .squashTag(squashTag),
    .violValid(violValid), .violTag(violTag)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: compares the violation output against queued expectations.
  always @(negedge clk) begin
    if (rst_n) begin
      if (expQ.size() > 0 && expQ[0].due == cyc) begin
        expItem_t it;
        it = expQ.pop_front();
        check({it.req, " violValid"}, int'(violValid), int'(it.v));
        if (it.v) check({it.req, " violTag"}, int'(violTag), it.tag);
      end else if (violValid) begin
        check("R10 spurious violValid", 1, 0);
      end
    end
  end

  task automatic idleAll();
    allocValid = 0; execValid = 0; stValid = 0;
    retireValid = 0; squashValid = 0;
  endtask

  task automatic doAlloc(int expTag, string req);
    @(negedge clk);
    idleAll();
    check({req, " allocTag"}, int'(allocTag), expTag);
    allocValid = 1;
  endtask

  task automatic doExec(int tag, logic [31:0] addr);
    @(negedge clk);
    idleAll();
    execValid = 1; execTag = TAGW'(tag); execAddr = addr;
  endtask

  task automatic doStore(logic [31:0] addr, int age, bit expV, int expTag, string req);
    expItem_t it;
    @(negedge clk);
    idleAll();
    stValid = 1; stAddr = addr; stAge = TAGW'(age);
    it.due = cyc + 1; it.v = expV; it.tag = expTag; it.req = req;
    expQ.push_back(it);
  endtask

  task automatic doRetire();
    @(negedge clk);
    idleAll();
    retireValid = 1;
  endtask

  task automatic doSquash(int tag);
    @(negedge clk);
    idleAll();
    squashValid = 1; squashTag = TAGW'(tag);
  endtask

  task automatic settle();
    @(negedge clk);
    idleAll();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check("R1 allocTag", int'(allocTag), 0);
    check("R1 lqFull", int'(lqFull), 0);
    check("R1 violValid", int'(violValid), 0);

    // R2 sequential tags
    for (int i = 0; i < 4; i++) doAlloc(i, "R2");
    doExec(1, 32'h100);
    doExec(2, 32'h100);
    doExec(3, 32'h200);
    settle();
    doStore(32'h100, 0, 1, 1, "R6 oldest of 1,2 / R4 tag0 unexecuted");
    doStore(32'h103, 2, 1, 2, "R5 older tag1 skipped / R7 low bits");
    doStore(32'h104, 0, 0, 0, "R7 bit2 differs");
    doStore(32'h200, 0, 1, 3, "R3 single match");
    doStore(32'h300, 0, 0, 0, "R10 no match");

    // R8 retirement
    doRetire();
    doRetire();
    settle();
    check("R8 allocTag after retire", int'(allocTag), 4);

    // R9 squash
    for (int i = 4; i < 7; i++) doAlloc(i, "R2");
    doExec(5, 32'h500);
    doExec(6, 32'h500);
    doSquash(4);
    settle();
    check("R9 allocTag after squash", int'(allocTag), 5);
    doStore(32'h500, 2, 0, 0, "R9 squashed loads removed");

    // wrap into reused slots, fill the queue
    for (int i = 5; i < 10; i++) doAlloc(i, "R2");
    settle();
    check("R2 full", int'(lqFull), 1);
    check("R2 allocTag full", int'(allocTag), 10);
    @(negedge clk);
    allocValid = 1;
    settle();
    check("R2 alloc ignored tag", int'(allocTag), 10);
    check("R2 alloc ignored full", int'(lqFull), 1);
    doStore(32'h100, 5, 0, 0, "R4 stale slot unexecuted");
    doStore(32'h500, 5, 0, 0, "R4 reused squashed slots");
    doExec(9, 32'h100);
    doExec(8, 32'h102);
    settle();
    doStore(32'h100, 7, 1, 8, "R6 oldest across wrap");
    doStore(32'h100, 9, 1, 9, "R3 youngest only");
    doStore(32'h101, 2, 1, 2, "R6 head entry oldest");

    doRetire();
    settle();
    check("R8 not full after retire", int'(lqFull), 0);
    check("R8 allocTag unchanged", int'(allocTag), 10);
    for (int i = 0; i < 7; i++) doRetire();
    settle();
    doStore(32'h100, 10, 0, 0, "R8 retired loads gone");
    repeat (3) settle();
    check("R3 all expectations consumed", expQ.size(), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule